// File: doc/BRIEF.md
# Timed FIFO Access Controller

This block stands between user logic and two frame queues owned by a bus controller: a receive queue that the controller fills and a transmit queue that it empties. User logic issues read requests and write requests, one at a time per direction. Each request carries a signed timeout in milliseconds. The block then either finishes the transfer, which pops one received frame or pushes one frame for transmission, or it gives up with an error flag once the timeout runs out. A failed request leaves the queue untouched. A timeout of zero is a pure poll that looks only at the queue state in the cycle the request arrives. Any negative timeout waits for as long as it takes.

Write requests also carry a command flag. This lets an abort-transmit command travel through the transmit path under the same timeout rules as a data frame, and the flag comes out next to the pushed word. Each direction has its own millisecond prescaler, built from a parameterised cycle count. The prescaler restarts when a request is accepted, so an expiry falls at an exact cycle offset from that acceptance.

Top module: `tfa_access_ctrl`

## Requirements
- R1: After reset, rd_done, wr_done, rx_pop and tx_push are all low.
- R2: A request with timeout 0 is resolved only from the queue state in its acceptance cycle. done pulses in the next cycle, with err low if the queue was ready and err high otherwise.
- R3: A request with a positive timeout N is still served if the queue becomes ready at any clock edge up to N*MS_CYCLES edges after acceptance. If the queue never becomes ready, done and err are raised after exactly edge N*MS_CYCLES.
- R4: When the queue becomes ready at the same edge where the timeout expires, the request completes with err low.
- R5: A timeout of -1, or any other negative value, never expires. The request completes with err low whenever the queue becomes ready.
- R6: A successful read pops exactly once while rx_empty is low, and rd_frame equals the head frame at rd_done. A failed read never pops, and rd_frame is 0 at rd_done.
- R7: A successful write pushes exactly once while tx_full is low, with tx_frame equal to the requested frame. A failed write never pushes.
- R8: The wr_abort flag of a write request appears on tx_abort together with its push (1 = abort command, 0 = data frame). Such a command follows the same timeout rules as a data frame.
- R9: A completed transfer raises done one cycle after the edge at which the queue was found ready. done lasts exactly one cycle and occurs once per accepted request.
- R10: A request presented while the same direction is still waiting is ignored: it neither changes the completion time nor the outcome of the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Read request strobe |
| rd_timeout | input | 32 | Signed read timeout in ms |
| rd_done | output | 1 | Read completion pulse |
| rd_err | output | 1 | Read ended without a frame |
| rd_frame | output | FRAME_W | Frame returned by the read |
| rx_empty | input | 1 | Receive queue empty |
| rx_frame | input | FRAME_W | Head of the receive queue (show-ahead) |
| rx_pop | output | 1 | Remove the head of the receive queue |
| wr_valid | input | 1 | Write request strobe |
| wr_timeout | input | 32 | Signed write timeout in ms |
| wr_frame | input | FRAME_W | Frame to queue for transmission |
| wr_abort | input | 1 | Request is an abort-transmit command |
| wr_done | output | 1 | Write completion pulse |
| wr_err | output | 1 | Write ended without queueing |
| tx_full | input | 1 | Transmit queue full |
| tx_push | output | 1 | Push into the transmit queue |
| tx_frame | output | FRAME_W | Word pushed into the transmit queue |
| tx_abort | output | 1 | Pushed word is an abort command |

## Verification
Both directions are swept across the same timeouts: 0, 1, 2, 3, -1 and -7 ms. For each timeout the queue becomes ready after one of several delays, measured in edges since acceptance. The delays fall before, exactly on and one edge after the expiry edge, and one case never becomes ready within the window. This separates poll, bounded and unbounded waiting and exposes any off-by-one in the prescaler or the counter. A second request is injected while a request is still pending, which shows whether the busy direction really ignores it. Alternating the abort flag on writes shows that it travels with the pushed word.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int TO_W = 32;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} wait_st_e;

  // Negative timeouts never expire.
  function automatic logic to_forever(input logic [TO_W-1:0] t);
    return t[TO_W-1];
  endfunction

  // Zero timeout is a pure poll.
  function automatic logic to_poll(input logic [TO_W-1:0] t);
    return t == '0;
  endfunction

  // Number of millisecond ticks to wait for a positive timeout.
  function automatic logic [TO_W-2:0] to_ticks(input logic [TO_W-1:0] t);
    return t[TO_W-2:0];
  endfunction
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int MS_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(MS_CYCLES - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (restart)         phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end

  assign tick = !restart && (phase_q == LAST);

  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (MS_CYCLES > 1 && tick) |=> !tick);
endmodule

// File: rtl/timed_waiter.sv
module timed_waiter
  import tfa_pkg::*;
#(
  parameter int MS_CYCLES = 200000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [TO_W-1:0] req_timeout,
  input  logic            cond_ok,
  output logic            accept,
  output logic            fire,
  output logic            done,
  output logic            err
);
  wait_st_e        state_q;
  logic [TO_W-2:0] remain_q;
  logic            forever_q;
  logic            tick;
  logic            examining;
  logic            poll_miss;
  logic            expire;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign examining = accept || (state_q == ST_WAIT);
  assign fire      = examining && cond_ok;
  assign poll_miss = accept && !cond_ok && to_poll(req_timeout);
  assign expire    = (state_q == ST_WAIT) && !forever_q && tick &&
                     (remain_q == (TO_W-1)'(1)) && !cond_ok;

  ms_tick_gen #(.MS_CYCLES(MS_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      remain_q  <= '0;
      forever_q <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= fire || poll_miss || expire;
      err  <= poll_miss || expire;
      case (state_q)
        ST_IDLE: if (accept && !fire && !poll_miss) begin
          state_q   <= ST_WAIT;
          remain_q  <= to_ticks(req_timeout);
          forever_q <= to_forever(req_timeout);
        end
        ST_WAIT: begin
          if (fire || expire) state_q <= ST_IDLE;
          else if (tick && !forever_q) remain_q <= remain_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fire_success_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (done && !err));
  p_poll_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && to_poll(req_timeout)) |=> done);
  p_forever_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && forever_q) |=> !err);
  p_err_only_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: rtl/tfa_access_ctrl.sv
module tfa_access_ctrl
  import tfa_pkg::*;
#(
  parameter int FRAME_W   = 64,
  parameter int MS_CYCLES = 200000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_valid,
  input  logic [31:0]        rd_timeout,
  output logic               rd_done,
  output logic               rd_err,
  output logic [FRAME_W-1:0] rd_frame,
  input  logic               rx_empty,
  input  logic [FRAME_W-1:0] rx_frame,
  output logic               rx_pop,
  input  logic               wr_valid,
  input  logic [31:0]        wr_timeout,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_abort,
  output logic               wr_done,
  output logic               wr_err,
  input  logic               tx_full,
  output logic               tx_push,
  output logic [FRAME_W-1:0] tx_frame,
  output logic               tx_abort
);
  logic rd_accept, rd_fire, wr_accept, wr_fire;
  logic [FRAME_W-1:0] rd_frame_q, wr_frame_q;
  logic               wr_abort_q;

  timed_waiter #(.MS_CYCLES(MS_CYCLES)) u_rd (
    .clk(clk), .rst_n(rst_n), .req_valid(rd_valid), .req_timeout(rd_timeout),
    .cond_ok(!rx_empty), .accept(rd_accept), .fire(rd_fire),
    .done(rd_done), .err(rd_err)
  );

  timed_waiter #(.MS_CYCLES(MS_CYCLES)) u_wr (
    .clk(clk), .rst_n(rst_n), .req_valid(wr_valid), .req_timeout(wr_timeout),
    .cond_ok(!tx_full), .accept(wr_accept), .fire(wr_fire),
    .done(wr_done), .err(wr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_frame_q <= '0;
    end else if (rd_fire) begin
      rd_frame_q <= rx_frame;
    end else if (rd_accept) begin
      rd_frame_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_frame_q <= '0;
      wr_abort_q <= 1'b0;
    end else if (wr_accept) begin
      wr_frame_q <= wr_frame;
      wr_abort_q <= wr_abort;
    end
  end

  assign rd_frame = rd_frame_q;
  assign rx_pop   = rd_fire;
  assign tx_push  = wr_fire;
  assign tx_frame = wr_accept ? wr_frame : wr_frame_q;
  assign tx_abort = wr_accept ? wr_abort : wr_abort_q;

  p_pop_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty);
  p_push_has_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> !tx_full);
  p_err_no_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rd_err) |-> (rd_frame == '0));
  p_pop_then_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> (rd_done && !rd_err && rd_frame == $past(rx_frame)));
endmodule

// File: tb/tb_tfa_access_ctrl.sv
`timescale 1ns/1ps
module tb_tfa_access_ctrl;
  localparam int FW = 16;
  localparam int T  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 0, wr_valid = 0, wr_abort = 0;
  logic [31:0] rd_timeout = '0, wr_timeout = '0;
  logic rx_empty = 1, tx_full = 1;
  logic [FW-1:0] rx_frame = '0, wr_frame = '0;
  logic rd_done, rd_err, rx_pop, wr_done, wr_err, tx_push, tx_abort;
  logic [FW-1:0] rd_frame, tx_frame;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tfa_access_ctrl #(.FRAME_W(FW), .MS_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_timeout(rd_timeout), .rd_done(rd_done),
    .rd_err(rd_err), .rd_frame(rd_frame), .rx_empty(rx_empty),
    .rx_frame(rx_frame), .rx_pop(rx_pop),
    .wr_valid(wr_valid), .wr_timeout(wr_timeout), .wr_frame(wr_frame),
    .wr_abort(wr_abort), .wr_done(wr_done), .wr_err(wr_err),
    .tx_full(tx_full), .tx_push(tx_push), .tx_frame(tx_frame),
    .tx_abort(tx_abort)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_ready(input bit dir, input bit r);
    if (dir) tx_full = !r; else rx_empty = !r;
  endtask

  task automatic set_req(input bit dir, input bit v, input int to);
    if (dir) begin wr_valid = v; wr_timeout = to; end
    else begin rd_valid = v; rd_timeout = to; end
  endtask

  // One request: queue turns ready at edge d after acceptance (edge 0).
  task automatic trial(input bit dir, input int to, input int d, input bit ab,
                       input logic [FW-1:0] frm);
    bit succ; int kexp; int nxfer = 0; int ndone = 0;
    bit gd, ge, gx; logic [FW-1:0] gf;
    string rq;
    if (to == 0)      begin succ = (d == 0); kexp = succ ? 0 : 0; end
    else if (to < 0)  begin succ = 1; kexp = d; end
    else              begin succ = (d <= to * T); kexp = succ ? d : to * T; end
    rq = (to == 0) ? "R2" : (to < 0) ? "R5" : (d == to * T) ? "R4" : "R3";
    rx_frame = frm; wr_frame = frm; wr_abort = ab;
    @(negedge clk);
    set_req(dir, 1, to);
    set_ready(dir, d == 0);
    for (int k = 0; k <= kexp; k++) begin
      #1;
      gx = dir ? tx_push : rx_pop;
      if (gx) begin
        nxfer++;
        if (dir) begin
          chk(tx_frame == frm, "R7", tx_frame, frm);
          chk(tx_abort == ab, "R8", tx_abort, ab);
        end else chk(!rx_empty, "R6", rx_empty, 0);
      end
      @(posedge clk); @(negedge clk);
      // R10: second request while waiting must be ignored
      set_req(dir, (k == 0 && kexp >= 1), 0);
      gd = dir ? wr_done : rd_done;
      ge = dir ? wr_err : rd_err;
      gf = rd_frame;
      if (gd) ndone++;
      chk(gd == (k == kexp), (k < kexp && k >= 1) ? "R10" : "R9", gd, k == kexp);
      if (k == kexp) begin
        chk(ge == !succ, rq, ge, !succ);
        if (!dir) chk(gf == (succ ? frm : '0), "R6", gf, succ ? frm : 0);
      end
      set_ready(dir, (k + 1) >= d);
    end
    set_ready(dir, 0);
    #1;
    @(negedge clk);
    gd = dir ? wr_done : rd_done;
    chk(!gd, "R9", gd, 0);
    chk(nxfer == int'(succ), dir ? "R7" : "R6", nxfer, succ);
    chk(ndone == 1, "R9", ndone, 1);
  endtask

  initial begin
    int tos[6] = '{0, 1, 2, 3, -1, -7};
    int ds[9]  = '{0, 1, 3, 4, 5, 8, 12, 13, 20};
    repeat (3) @(negedge clk);
    chk(!rd_done && !wr_done && !rx_pop && !tx_push, "R1",
        {rd_done, wr_done, rx_pop, tx_push}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_done && !wr_done && !rx_pop && !tx_push, "R1",
        {rd_done, wr_done, rx_pop, tx_push}, 0);
    for (int dir = 0; dir < 2; dir++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 9; j++)
          trial(dir[0], tos[i], ds[j], (i + j) % 2 == 1,
                FW'(16'h1000 + dir * 256 + i * 16 + j));
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule